// File: doc/BRIEF.md
# Command Sequencer with Deferred Issue

This block is the command-issuing side of a multimedia card host. Software hands it a command in one write: a 6-bit command index, a 32-bit argument, an enable flag and a defer flag. The block turns this into a 48-bit frame and shifts it out on the single command line, one bit per clock, most significant bit first. It drives the line's output-enable while the frame is on the wire, and flags completion with a one-cycle done pulse.

When the defer flag is set and the data path is running a stream transfer, the block does not transmit at once. It holds the command in a waiting state until the data path raises a trigger pulse to signal that its data counter has run out. The command goes out on the next cycle. The usual purpose is to place a stop command on the line exactly when a stream transfer ends. In block transfers the defer flag has no effect. A write that clears the enable flag while a command waits cancels that command. Response capture, timeouts and clock division are handled by other blocks.

Top module: `mmc_cmd_sequencer`

## Requirements
- R1: After reset the block is idle: busy=0, done=0, cmd_oe=0 and cmd_out=1.
- R2: An accepted immediate command drives cmd_oe high for exactly 48 consecutive cycles, starting in the cycle after the write. In those cycles cmd_out carries, MSB first: bit 47 = 0 (start), bit 46 = 1 (direction), bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC, bit 0 = 1 (end). Whenever cmd_oe is low, cmd_out is 1.
- R3: The CRC field is the 7-bit remainder of frame bits 47:8 for the polynomial x^7+x^3+1, with the register starting at zero.
- R4: done is high for exactly one cycle, in the cycle directly after the end bit. In that cycle busy is already 0 and cmd_oe is 0.
- R5: A write with enable=1 and defer=1 while stream_mode=1 does not transmit. busy stays 1, cmd_oe stays 0 and done stays 0 until a trigger pulse arrives.
- R6: A pend_pulse sampled while a command waits starts that command's frame in the next cycle, with the frame the write supplied.
- R7: With stream_mode=0, the defer flag is ignored and the command is sent as in R2.
- R8: pend_pulse has no effect while idle, including a pulse in the same cycle as the deferring write, and no effect while a frame is being sent.
- R9: A write with enable=0 while a command waits cancels it. busy is 0 from the next cycle, and no frame and no done pulse follow.
- R10: Writes are ignored while a command waits with enable=1, or while a frame is being sent, and also while idle with enable=0. The frame that goes out is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_index | input | 6 | Command index |
| wr_arg | input | 32 | Command argument |
| wr_enable | input | 1 | Enable flag of the write |
| wr_defer | input | 1 | Defer-until-trigger flag of the write |
| stream_mode | input | 1 | Data path is in stream mode |
| pend_pulse | input | 1 | Trigger from the data path, data counter reached zero |
| cmd_out | output | 1 | Serial command line |
| cmd_oe | output | 1 | Command line output-enable |
| done | output | 1 | One-cycle pulse after the end bit |
| busy | output | 1 | Command waiting or being sent |

## Verification
Random indices and arguments are sent both immediately and deferred, with a random wait before the trigger. This separates frame layout and CRC errors from timing errors in the deferred release. Directed cases place the trigger in the idle state, in the same cycle as the deferring write and in the middle of a frame. Separately, writes arrive in the middle of a frame, in the waiting state and while idle with enable clear. These cases show whether stray events are ignored, or whether they start, corrupt or restart transmission. Deferred writes in block mode and cancellations check that the defer flag depends on the transfer mode and that an aborted command leaves the line undriven and raises no done.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int IDX_W_DEF  = 6;
    localparam int ARG_W_DEF  = 32;
    localparam int CRC_W_DEF  = 7;
    localparam logic [6:0] CRC_POLY_DEF = 7'h09;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_SEND = 2'd2
    } mcs_state_t;
endpackage

// File: rtl/mcs_crc.sv
module mcs_crc #(
    parameter int DATA_W = 40,
    parameter int CRC_W  = 7,
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = data[i] ^ acc[CRC_W-1];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc = acc;
    end
endmodule

// File: rtl/mcs_framer.sv
module mcs_framer #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    parameter int CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY = 7'h09,
    localparam int BODY_W  = 2 + IDX_W + ARG_W,
    localparam int FRAME_W = BODY_W + CRC_W + 1
) (
    input  logic [IDX_W-1:0]   index,
    input  logic [ARG_W-1:0]   arg,
    output logic [FRAME_W-1:0] frame
);
    logic [BODY_W-1:0] body;
    logic [CRC_W-1:0]  crc;

    assign body = {1'b0, 1'b1, index, arg};

    mcs_crc #(
        .DATA_W (BODY_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY)
    ) u_crc (
        .data (body),
        .crc  (crc)
    );

    assign frame = {body, crc, 1'b1};
endmodule

// File: rtl/mcs_shifter.sv
module mcs_shifter #(
    parameter int FRAME_W = 48,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               shift,
    output logic               msb,
    output logic               last
);
    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [CNT_W-1:0]   cnt;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sreg = frame;
            s_d.cnt  = '0;
        end else if (shift) begin
            s_d.sreg = {s_q.sreg[FRAME_W-2:0], 1'b1};
            s_d.cnt  = (s_q.cnt == CNT_W'(FRAME_W - 1)) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{sreg: '1, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign msb  = s_q.sreg[FRAME_W-1];
    assign last = (s_q.cnt == CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_enable,
    input  logic wr_defer,
    input  logic stream_mode,
    input  logic pend_pulse,
    input  logic last,
    output logic load,
    output logic shift,
    output logic oe,
    output logic busy,
    output logic done
);
    typedef struct packed {
        mcs_state_t state;
        logic       done;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load     = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (wr_en && wr_enable) begin
                    load = 1'b1;
                    c_d.state = (wr_defer && stream_mode) ? ST_PEND : ST_SEND;
                end
            end
            ST_PEND: begin
                if (wr_en && !wr_enable) begin
                    c_d.state = ST_IDLE;
                end else if (pend_pulse) begin
                    c_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (last) begin
                    c_d.state = ST_IDLE;
                    c_d.done  = 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign shift = (c_q.state == ST_SEND);
    assign oe    = (c_q.state == ST_SEND);
    assign busy  = (c_q.state != ST_IDLE);
    assign done  = c_q.done;
endmodule

// File: rtl/mmc_cmd_sequencer.sv
module mmc_cmd_sequencer
    import mcs_pkg::*;
#(
    parameter int IDX_W = IDX_W_DEF,
    parameter int ARG_W = ARG_W_DEF,
    parameter int CRC_W = CRC_W_DEF,
    parameter logic [CRC_W-1:0] CRC_POLY = CRC_POLY_DEF,
    localparam int FRAME_W = 2 + IDX_W + ARG_W + CRC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [ARG_W-1:0] wr_arg,
    input  logic             wr_enable,
    input  logic             wr_defer,
    input  logic             stream_mode,
    input  logic             pend_pulse,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             done,
    output logic             busy
);
    logic [FRAME_W-1:0] frame;
    logic               load, shift, msb, last, oe;

    mcs_framer #(
        .IDX_W (IDX_W),
        .ARG_W (ARG_W),
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY)
    ) u_framer (
        .index (wr_index),
        .arg   (wr_arg),
        .frame (frame)
    );

    mcs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_enable   (wr_enable),
        .wr_defer    (wr_defer),
        .stream_mode (stream_mode),
        .pend_pulse  (pend_pulse),
        .last        (last),
        .load        (load),
        .shift       (shift),
        .oe          (oe),
        .busy        (busy),
        .done        (done)
    );

    mcs_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .frame (frame),
        .shift (shift),
        .msb   (msb),
        .last  (last)
    );

    assign cmd_oe  = oe;
    assign cmd_out = oe ? msb : 1'b1;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_enable,
    input logic wr_defer,
    input logic stream_mode,
    input logic pend_pulse,
    input logic cmd_out,
    input logic cmd_oe,
    input logic done,
    input logic busy
);
    // R2: line idles high whenever not driven
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);

    // R2: a frame begins with the start bit
    a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);

    // R4: done lasts one cycle and follows the last driven bit
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cmd_oe) && !cmd_oe && !busy));

    // R6: transmission starts only after a write or a trigger
    a_r6_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> ($past(wr_en) || $past(pend_pulse)));

    // R7: block-mode command is sent at once
    a_r7_block_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_enable && !stream_mode && !busy) |=> cmd_oe);

    // R9: busy falls only at frame end or on a cancelling write
    a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || ($past(wr_en) && !$past(wr_enable))));

    // R5: a deferred stream write does not drive the line at once
    a_r5_defer_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_enable && wr_defer && stream_mode && !busy) |=> (busy && !cmd_oe));
endmodule

bind mmc_cmd_sequencer mcs_checker u_mcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_enable   (wr_enable),
    .wr_defer    (wr_defer),
    .stream_mode (stream_mode),
    .pend_pulse  (pend_pulse),
    .cmd_out     (cmd_out),
    .cmd_oe      (cmd_oe),
    .done        (done),
    .busy        (busy)
);

// File: tb/mmc_cmd_sequencer_bench.sv
`timescale 1ns/1ps
module mmc_cmd_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [31:0] wr_arg = '0;
    logic        wr_enable = 1'b0;
    logic        wr_defer = 1'b0;
    logic        stream_mode = 1'b0;
    logic        pend_pulse = 1'b0;
    logic        cmd_out, cmd_oe, done, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit inj_wr = 0;
    bit inj_pulse = 0;

    always #5 clk = ~clk;

    mmc_cmd_sequencer u_mmc_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_index(wr_index),
        .wr_arg(wr_arg), .wr_enable(wr_enable), .wr_defer(wr_defer),
        .stream_mode(stream_mode), .pend_pulse(pend_pulse),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done(done), .busy(busy)
    );

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            if (d[i] ^ r[6]) r = {r[5:0], 1'b0} ^ 7'h09;
            else             r = {r[5:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] a);
        logic [39:0] b = {2'b01, idx, a};
        return {b, ref_crc(b), 1'b1};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [5:0] idx, input logic [31:0] a, input bit en,
                         input bit dfr, input bit pls);
        @(negedge clk);
        wr_en = 1'b1; wr_index = idx; wr_arg = a; wr_enable = en; wr_defer = dfr;
        pend_pulse = pls;
        @(negedge clk);
        wr_en = 1'b0; pend_pulse = 1'b0;
        wr_index = $urandom; wr_arg = $urandom;
    endtask

    // called at the negedge where bit 47 is on the line
    task automatic capture(input logic [47:0] exp, input string req);
        logic [47:0] got = '0;
        bit oe_ok = 1;
        for (int i = 47; i >= 0; i--) begin
            if (i != 47) @(negedge clk);
            got[i] = cmd_out;
            if (!cmd_oe || !busy || done) oe_ok = 0;
            if (i == 30 && (inj_wr || inj_pulse)) begin
                wr_en = inj_wr; wr_enable = 1'b1; wr_defer = 1'b0;
                wr_index = ~exp[45:40]; wr_arg = ~exp[39:8];
                pend_pulse = inj_pulse;
            end else begin
                wr_en = 1'b0; pend_pulse = 1'b0;
            end
        end
        check(got == exp, {req, " R2 R3 frame"}, 64'(got), 64'(exp));
        check(oe_ok, {req, " R2 oe window"}, 64'(oe_ok), 64'd1);
        @(negedge clk);
        check(done && !busy && !cmd_oe && cmd_out, {req, " R4 done after end"},
              {60'd0, done, busy, cmd_oe, cmd_out}, 64'b1001);
        @(negedge clk);
        check(!done && !busy && !cmd_oe, {req, " R4 done one cycle"},
              {61'd0, done, busy, cmd_oe}, 64'd0);
    endtask

    task automatic quiet(input int n, input bit exp_busy, input string req);
        bit ok = 1;
        for (int i = 0; i < n; i++) begin
            if (cmd_oe || !cmd_out || done || busy != exp_busy) ok = 0;
            @(negedge clk);
        end
        if (cmd_oe || !cmd_out || done || busy != exp_busy) ok = 0;
        check(ok, req, {60'd0, cmd_oe, cmd_out, done, busy}, {63'd0, exp_busy} | 64'b0100);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0]  idx;
        logic [31:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!busy && !done && !cmd_oe && cmd_out, "R1 in reset",
              {60'd0, busy, done, cmd_oe, cmd_out}, 64'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmd_oe && cmd_out, "R1 after reset",
              {60'd0, busy, done, cmd_oe, cmd_out}, 64'b0001);

        // R2 R3: known vector, index 0 argument 0 gives CRC 0x4A
        check(ref_crc(40'h40_0000_0000) == 7'h4A, "R3 crc reference", 64'(ref_crc(40'h4000000000)), 64'h4A);
        stream_mode = 1'b0;
        write(6'd0, 32'd0, 1, 0, 0);
        capture(ref_frame(6'd0, 32'd0), "R2 cmd0");

        // R7: defer flag in block mode
        write(6'd12, 32'hDEAD_BEEF, 1, 1, 0);
        capture(ref_frame(6'd12, 32'hDEAD_BEEF), "R7 block defer");

        // R10: enable clear while idle is ignored
        write(6'd5, 32'h1, 0, 0, 0);
        quiet(10, 0, "R10 idle write enable=0");

        // R8: pulse while idle
        @(negedge clk); pend_pulse = 1'b1; @(negedge clk); pend_pulse = 1'b0;
        quiet(5, 0, "R8 idle pulse");

        // R5 R8: pulse in the same cycle as the deferring write
        stream_mode = 1'b1;
        write(6'd12, 32'h0000_0003, 1, 1, 1);
        quiet(20, 1, "R5 R8 pulse with write ignored");
        // R10: enable=1 write while waiting is ignored
        write(6'd40, 32'h5555_AAAA, 1, 0, 0);
        quiet(4, 1, "R10 write in wait");
        @(negedge clk); pend_pulse = 1'b1; @(negedge clk); pend_pulse = 1'b0;
        capture(ref_frame(6'd12, 32'h3), "R6 release");

        // R9: cancel
        write(6'd7, 32'h77, 1, 1, 0);
        quiet(6, 1, "R5 wait before cancel");
        write(6'd7, 32'h77, 0, 0, 0);
        check(!busy && !cmd_oe, "R9 cancel busy low", {62'd0, busy, cmd_oe}, 64'd0);
        @(negedge clk); pend_pulse = 1'b1; @(negedge clk); pend_pulse = 1'b0;
        quiet(60, 0, "R9 no frame after cancel");

        // R10: write mid-frame
        inj_wr = 1;
        write(6'd17, 32'hCAFE_0001, 1, 0, 0);
        capture(ref_frame(6'd17, 32'hCAFE_0001), "R10 write mid-frame");
        inj_wr = 0;
        quiet(3, 0, "R10 no second frame");

        // R8: pulse mid-frame
        inj_pulse = 1;
        write(6'd18, 32'h1234_5678, 1, 1, 0);
        @(negedge clk); pend_pulse = 1'b1; @(negedge clk); pend_pulse = 1'b0;
        capture(ref_frame(6'd18, 32'h1234_5678), "R8 pulse mid-frame");
        inj_pulse = 0;

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit dfr, strm;
            idx = $urandom; a = $urandom;
            dfr = $urandom_range(0, 1); strm = $urandom_range(0, 1);
            stream_mode = strm;
            write(idx, a, 1, dfr, 0);
            if (dfr && strm) begin
                quiet($urandom_range(0, 12), 1, "R5 random wait");
                @(negedge clk); pend_pulse = 1'b1; @(negedge clk); pend_pulse = 1'b0;
                capture(ref_frame(idx, a), "R6 random deferred");
            end else begin
                capture(ref_frame(idx, a), strm ? "R2 random" : "R7 random block");
            end
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule